// File: doc/BRIEF.md
# Ring-Counter Instruction Sequencer

This block is the control unit of a small accumulator machine with a 12-bit word. A six-phase one-hot ring counter divides every instruction into the phases T0 to T5. The first three phases fetch the word and the last three execute it. During the fetch the unit latches the instruction word from the shared bus and splits it into a 4-bit opcode and an 8-bit operand field. The lower six bits of that field are also presented as a latched microcode field, which the external ALU and the stack and I/O selection logic decode. From the phase, the opcode and three condition flags (equal, greater, negative) the unit drives single-bit control strobes. These cover the program counter, the memory address and data registers, memory read and write, the accumulator and B register, the ALU, the stack counter and the bus I/O port.

The program counter is held inside the block. It increments during fetch and loads from the low bits of the bus when a jump is taken. A conditional jump uses the same strobes as an unconditional one, except that the PC-load strobe is gated off when its flag is false. The instruction then falls through to the next word. The datapath registers, the memory array and the ALU arithmetic sit outside the block and respond only to the strobes.

Top module: `ring_sequencer`

## Requirements
- R1: `phase_o` is one-hot. Bit k means phase Tk. It moves from Tk to Tk+1 on every clock and wraps from T5 back to T0.
- R2: While `rst` is high at a clock edge, the phase becomes T0 and `pc_o` becomes 0. After reset is released, the first phase is T0.
- R3: Fetch, for every opcode. In T0: pc_drive and mar_load. In T1: mem_read and mdr_load. In T2: mdr_drive, ir_load and pc_inc. The PC reads one more than before from T3 onward.
- R4: At the end of T2, `bus_i[11:8]` is latched as `opcode_o` and `bus_i[7:0]` as `operand_o`. `micro_o` equals `operand_o[5:0]`. All three hold until the next T2.
- R5: Data moves, by opcode. 0 (immediate): T3 ir_drive and acc_load. 1 (recall): T3 ir_drive and mar_load, T4 mem_read and mdr_load, T5 mdr_drive and acc_load. 2 (store): T3 ir_drive and mar_load, T4 acc_drive and mem_write. 5 (A to B): T3 acc_drive and b_load. 8 (PC to A): T3 pc_drive and acc_load.
- R6: Opcode 3 (ALU operation) asserts alu_strobe, alu_drive and acc_load in T3. The operation is chosen externally from `micro_o`.
- R7: Opcode 4 (jump from A) asserts acc_drive and pc_load in T3. Opcode 6 (jump) asserts ir_drive and pc_load in T3. A pc_load makes `pc_o` equal to `bus_i[7:0]` from T4 onward.
- R8: Opcodes 7 (if equal, `eq_i`), D (if greater, `gt_i`) and E (if negative, `neg_i`) assert ir_drive in T3. They assert pc_load only when their flag is high. Otherwise the PC keeps its incremented value.
- R9: Opcode 9 (push): T3 stk_inc, then T4 acc_drive and stk_load. Opcode A (pop): T3 stk_drive and acc_load, then T4 stk_dec. Opcode F (counter): in T3, stk_dec when `operand_o[0]` is 1, otherwise stk_inc.
- R10: Opcode B (input) asserts io_recv and acc_load in T3. Opcode C (output) asserts acc_drive and io_send in T3.
- R11: Every strobe not named above for a given phase and opcode is low. At most one bus source is active in any phase. The bus sources are pc_drive, mdr_drive, ir_drive, acc_drive, alu_drive, stk_drive and io_recv. mem_read and mem_write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 12 | Shared data bus as seen by the sequencer |
| eq_i | input | 1 | A equals B flag |
| gt_i | input | 1 | A greater than B flag |
| neg_i | input | 1 | Accumulator negative flag |
| phase_o | output | 6 | One-hot phase T0..T5 |
| pc_o | output | 8 | Program counter |
| opcode_o | output | 4 | Latched opcode |
| operand_o | output | 8 | Latched operand field |
| micro_o | output | 6 | Latched microcode field |
| pc_drive_o | output | 1 | PC onto bus |
| pc_inc_o | output | 1 | PC increment |
| pc_load_o | output | 1 | PC load from bus |
| mar_load_o | output | 1 | Address register load |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| mdr_load_o | output | 1 | Data register load from memory |
| mdr_drive_o | output | 1 | Data register onto bus |
| ir_load_o | output | 1 | Instruction latch load |
| ir_drive_o | output | 1 | Operand field onto bus |
| acc_load_o | output | 1 | Accumulator load |
| acc_drive_o | output | 1 | Accumulator onto bus |
| b_load_o | output | 1 | B register load |
| alu_strobe_o | output | 1 | ALU compute |
| alu_drive_o | output | 1 | ALU result onto bus |
| stk_inc_o | output | 1 | Stack counter increment |
| stk_dec_o | output | 1 | Stack counter decrement |
| stk_load_o | output | 1 | Stack write from bus |
| stk_drive_o | output | 1 | Stack onto bus |
| io_send_o | output | 1 | I/O device receives from bus |
| io_recv_o | output | 1 | I/O device sends onto bus |

## Verification
The assertions take for granted that the flags stay steady through the execute phases. They also assume the external datapath places the instruction word on the bus in T2 and the jump target in T3, since those are the only phases in which the block samples the bus. The stimulus keeps to these conditions: it holds each flag combination for a whole instruction and changes the bus only between clock edges, in the phases that consume it. It sweeps all sixteen opcodes against all eight flag combinations, adds a reset mid-instruction, and checks the strobes phase by phase.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IMM  = 4'h0,
        OP_RCL  = 4'h1,
        OP_STO  = 4'h2,
        OP_ALU  = 4'h3,
        OP_JACC = 4'h4,
        OP_MAB  = 4'h5,
        OP_JMP  = 4'h6,
        OP_JEQ  = 4'h7,
        OP_PCA  = 4'h8,
        OP_PSH  = 4'h9,
        OP_POP  = 4'hA,
        OP_INA  = 4'hB,
        OP_OUT  = 4'hC,
        OP_JGT  = 4'hD,
        OP_JNEG = 4'hE,
        OP_CTR  = 4'hF
    } opcode_e;

    typedef struct packed {
        logic pc_drive;
        logic pc_inc;
        logic pc_load;
        logic mar_load;
        logic mem_read;
        logic mem_write;
        logic mdr_load;
        logic mdr_drive;
        logic ir_load;
        logic ir_drive;
        logic acc_load;
        logic acc_drive;
        logic b_load;
        logic alu_strobe;
        logic alu_drive;
        logic stk_inc;
        logic stk_dec;
        logic stk_load;
        logic stk_drive;
        logic io_send;
        logic io_recv;
    } strobes_t;

    // Every strobe that places a value on the shared bus.
    function automatic logic [6:0] bus_sources(strobes_t s);
        return {s.pc_drive, s.mdr_drive, s.ir_drive, s.acc_drive,
                s.alu_drive, s.stk_drive, s.io_recv};
    endfunction

endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
    parameter int N_PHASE = 6
) (
    input  logic               clk,
    input  logic               rst,
    output logic [N_PHASE-1:0] phase_o
);
    always_ff @(posedge clk) begin
        if (rst)
            phase_o <= {{(N_PHASE-1){1'b0}}, 1'b1};
        else
            phase_o <= {phase_o[N_PHASE-2:0], phase_o[N_PHASE-1]};
    end

    assert_ring_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase_o));

    assert_ring_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        phase_o[N_PHASE-1] |=> phase_o[0]);
endmodule

// File: rtl/instr_latch.sv
module instr_latch
    import rseq_pkg::*;
#(
    parameter int WORD_W  = 12,
    localparam int FIELD_W = WORD_W - OP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [WORD_W-1:0]  word_i,
    output opcode_e            opcode_o,
    output logic [FIELD_W-1:0] field_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_o <= OP_IMM;
            field_o  <= '0;
        end else if (load) begin
            opcode_o <= opcode_e'(word_i[WORD_W-1 -: OP_W]);
            field_o  <= word_i[FIELD_W-1:0];
        end
    end

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(opcode_o) && $stable(field_o)));
endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc_o
);
    always_ff @(posedge clk) begin
        if (rst)
            pc_o <= '0;
        else if (load)
            pc_o <= load_val;
        else if (inc)
            pc_o <= pc_o + ADDR_W'(1);
    end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import rseq_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int N_PHASE = 6
) (
    input  logic [N_PHASE-1:0] phase_i,
    input  opcode_e            opcode_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               eq_i,
    input  logic               gt_i,
    input  logic               neg_i,
    output strobes_t           strobes_o
);
    logic take_jump;

    always_comb begin
        unique case (opcode_i)
            OP_JEQ:  take_jump = eq_i;
            OP_JGT:  take_jump = gt_i;
            OP_JNEG: take_jump = neg_i;
            default: take_jump = 1'b1;
        endcase
    end

    always_comb begin
        strobes_o = '0;
        // fetch
        if (phase_i[0]) begin
            strobes_o.pc_drive = 1'b1;
            strobes_o.mar_load = 1'b1;
        end
        if (phase_i[1]) begin
            strobes_o.mem_read = 1'b1;
            strobes_o.mdr_load = 1'b1;
        end
        if (phase_i[2]) begin
            strobes_o.mdr_drive = 1'b1;
            strobes_o.ir_load   = 1'b1;
            strobes_o.pc_inc    = 1'b1;
        end
        // execute, first phase
        if (phase_i[3]) begin
            case (opcode_i)
                OP_IMM: begin
                    strobes_o.ir_drive = 1'b1;
                    strobes_o.acc_load = 1'b1;
                end
                OP_RCL, OP_STO: begin
                    strobes_o.ir_drive = 1'b1;
                    strobes_o.mar_load = 1'b1;
                end
                OP_ALU: begin
                    strobes_o.alu_strobe = 1'b1;
                    strobes_o.alu_drive  = 1'b1;
                    strobes_o.acc_load   = 1'b1;
                end
                OP_JACC: begin
                    strobes_o.acc_drive = 1'b1;
                    strobes_o.pc_load   = 1'b1;
                end
                OP_MAB: begin
                    strobes_o.acc_drive = 1'b1;
                    strobes_o.b_load    = 1'b1;
                end
                OP_JMP, OP_JEQ, OP_JGT, OP_JNEG: begin
                    strobes_o.ir_drive = 1'b1;
                    strobes_o.pc_load  = take_jump;
                end
                OP_PCA: begin
                    strobes_o.pc_drive = 1'b1;
                    strobes_o.acc_load = 1'b1;
                end
                OP_PSH: strobes_o.stk_inc = 1'b1;
                OP_POP: begin
                    strobes_o.stk_drive = 1'b1;
                    strobes_o.acc_load  = 1'b1;
                end
                OP_INA: begin
                    strobes_o.io_recv  = 1'b1;
                    strobes_o.acc_load = 1'b1;
                end
                OP_OUT: begin
                    strobes_o.acc_drive = 1'b1;
                    strobes_o.io_send   = 1'b1;
                end
                OP_CTR: begin
                    strobes_o.stk_dec = field_i[0];
                    strobes_o.stk_inc = !field_i[0];
                end
                default: ;
            endcase
        end
        // execute, second phase
        if (phase_i[4]) begin
            case (opcode_i)
                OP_RCL: begin
                    strobes_o.mem_read = 1'b1;
                    strobes_o.mdr_load = 1'b1;
                end
                OP_STO: begin
                    strobes_o.acc_drive = 1'b1;
                    strobes_o.mem_write = 1'b1;
                end
                OP_PSH: begin
                    strobes_o.acc_drive = 1'b1;
                    strobes_o.stk_load  = 1'b1;
                end
                OP_POP: strobes_o.stk_dec = 1'b1;
                default: ;
            endcase
        end
        // execute, third phase
        if (phase_i[5] && opcode_i == OP_RCL) begin
            strobes_o.mdr_drive = 1'b1;
            strobes_o.acc_load  = 1'b1;
        end
    end
endmodule

// File: rtl/ring_sequencer.sv
module ring_sequencer
    import rseq_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int ADDR_W  = 8,
    parameter int MICRO_W = 6,
    localparam int FIELD_W = WORD_W - OP_W,
    localparam int N_PHASE = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  bus_i,
    input  logic               eq_i,
    input  logic               gt_i,
    input  logic               neg_i,
    output logic [N_PHASE-1:0] phase_o,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [OP_W-1:0]    opcode_o,
    output logic [FIELD_W-1:0] operand_o,
    output logic [MICRO_W-1:0] micro_o,
    output logic               pc_drive_o,
    output logic               pc_inc_o,
    output logic               pc_load_o,
    output logic               mar_load_o,
    output logic               mem_read_o,
    output logic               mem_write_o,
    output logic               mdr_load_o,
    output logic               mdr_drive_o,
    output logic               ir_load_o,
    output logic               ir_drive_o,
    output logic               acc_load_o,
    output logic               acc_drive_o,
    output logic               b_load_o,
    output logic               alu_strobe_o,
    output logic               alu_drive_o,
    output logic               stk_inc_o,
    output logic               stk_dec_o,
    output logic               stk_load_o,
    output logic               stk_drive_o,
    output logic               io_send_o,
    output logic               io_recv_o
);
    logic [N_PHASE-1:0] phase;
    opcode_e            opcode;
    logic [FIELD_W-1:0] field;
    strobes_t           s;
    logic [ADDR_W-1:0]  pc;

    phase_ring #(.N_PHASE(N_PHASE)) u_ring (
        .clk(clk), .rst(rst), .phase_o(phase)
    );

    instr_latch #(.WORD_W(WORD_W)) u_latch (
        .clk(clk), .rst(rst), .load(s.ir_load), .word_i(bus_i),
        .opcode_o(opcode), .field_o(field)
    );

    strobe_decode #(.FIELD_W(FIELD_W), .N_PHASE(N_PHASE)) u_decode (
        .phase_i(phase), .opcode_i(opcode), .field_i(field),
        .eq_i(eq_i), .gt_i(gt_i), .neg_i(neg_i), .strobes_o(s)
    );

    prog_counter #(.ADDR_W(ADDR_W)) u_pc (
        .clk(clk), .rst(rst), .inc(s.pc_inc), .load(s.pc_load),
        .load_val(bus_i[ADDR_W-1:0]), .pc_o(pc)
    );

    assign phase_o      = phase;
    assign pc_o         = pc;
    assign opcode_o     = opcode;
    assign operand_o    = field;
    assign micro_o      = field[MICRO_W-1:0];
    assign pc_drive_o   = s.pc_drive;
    assign pc_inc_o     = s.pc_inc;
    assign pc_load_o    = s.pc_load;
    assign mar_load_o   = s.mar_load;
    assign mem_read_o   = s.mem_read;
    assign mem_write_o  = s.mem_write;
    assign mdr_load_o   = s.mdr_load;
    assign mdr_drive_o  = s.mdr_drive;
    assign ir_load_o    = s.ir_load;
    assign ir_drive_o   = s.ir_drive;
    assign acc_load_o   = s.acc_load;
    assign acc_drive_o  = s.acc_drive;
    assign b_load_o     = s.b_load;
    assign alu_strobe_o = s.alu_strobe;
    assign alu_drive_o  = s.alu_drive;
    assign stk_inc_o    = s.stk_inc;
    assign stk_dec_o    = s.stk_dec;
    assign stk_load_o   = s.stk_load;
    assign stk_drive_o  = s.stk_drive;
    assign io_send_o    = s.io_send;
    assign io_recv_o    = s.io_recv;

    assert_single_driver_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_sources(s)));

    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(s.mem_read && s.mem_write));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        s.pc_inc |=> (pc == $past(pc) + ADDR_W'(1)));

    assert_cond_fallthrough_R8: assert property (@(posedge clk) disable iff (rst)
        (phase[3] && ((opcode == OP_JEQ && !eq_i) || (opcode == OP_JGT && !gt_i) ||
                      (opcode == OP_JNEG && !neg_i))) |=> (pc == $past(pc)));

    assert_load_phase_R7: assert property (@(posedge clk) disable iff (rst)
        s.pc_load |-> phase[3]);
endmodule

// File: tb/ring_sequencer_test.sv
`timescale 1ns/1ps
module ring_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_i = '0;
    logic        eq_i = 1'b0, gt_i = 1'b0, neg_i = 1'b0;
    logic [5:0]  phase_o;
    logic [7:0]  pc_o;
    logic [3:0]  opcode_o;
    logic [7:0]  operand_o;
    logic [5:0]  micro_o;
    logic pc_drive_o, pc_inc_o, pc_load_o, mar_load_o, mem_read_o, mem_write_o;
    logic mdr_load_o, mdr_drive_o, ir_load_o, ir_drive_o, acc_load_o, acc_drive_o;
    logic b_load_o, alu_strobe_o, alu_drive_o, stk_inc_o, stk_dec_o, stk_load_o;
    logic stk_drive_o, io_send_o, io_recv_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ring_sequencer uut (
        .clk(clk), .rst(rst), .bus_i(bus_i), .eq_i(eq_i), .gt_i(gt_i), .neg_i(neg_i),
        .phase_o(phase_o), .pc_o(pc_o), .opcode_o(opcode_o), .operand_o(operand_o),
        .micro_o(micro_o), .pc_drive_o(pc_drive_o), .pc_inc_o(pc_inc_o),
        .pc_load_o(pc_load_o), .mar_load_o(mar_load_o), .mem_read_o(mem_read_o),
        .mem_write_o(mem_write_o), .mdr_load_o(mdr_load_o), .mdr_drive_o(mdr_drive_o),
        .ir_load_o(ir_load_o), .ir_drive_o(ir_drive_o), .acc_load_o(acc_load_o),
        .acc_drive_o(acc_drive_o), .b_load_o(b_load_o), .alu_strobe_o(alu_strobe_o),
        .alu_drive_o(alu_drive_o), .stk_inc_o(stk_inc_o), .stk_dec_o(stk_dec_o),
        .stk_load_o(stk_load_o), .stk_drive_o(stk_drive_o), .io_send_o(io_send_o),
        .io_recv_o(io_recv_o)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [20:0] got_vec();
        return {pc_drive_o, pc_inc_o, pc_load_o, mar_load_o, mem_read_o, mem_write_o,
                mdr_load_o, mdr_drive_o, ir_load_o, ir_drive_o, acc_load_o, acc_drive_o,
                b_load_o, alu_strobe_o, alu_drive_o, stk_inc_o, stk_dec_o, stk_load_o,
                stk_drive_o, io_send_o, io_recv_o};
    endfunction

    function automatic logic [20:0] exp_vec(int p, logic [3:0] op, logic [7:0] f,
                                            logic eq, logic gt, logic ng);
        logic pcd = 0, pci = 0, pcl = 0, mar = 0, mrd = 0, mwr = 0, mdl = 0, mdd = 0;
        logic irl = 0, ird = 0, acl = 0, acd = 0, bl = 0, als = 0, ald = 0;
        logic si = 0, sd = 0, sl = 0, sdr = 0, ios = 0, ior = 0;
        if (p == 0) begin pcd = 1; mar = 1; end          // R3
        if (p == 1) begin mrd = 1; mdl = 1; end
        if (p == 2) begin mdd = 1; irl = 1; pci = 1; end
        if (p == 3) begin
            if (op == 4'h0) begin ird = 1; acl = 1; end  // R5
            if (op == 4'h1 || op == 4'h2) begin ird = 1; mar = 1; end
            if (op == 4'h3) begin als = 1; ald = 1; acl = 1; end  // R6
            if (op == 4'h4) begin acd = 1; pcl = 1; end  // R7
            if (op == 4'h5) begin acd = 1; bl = 1; end
            if (op == 4'h6) begin ird = 1; pcl = 1; end
            if (op == 4'h7) begin ird = 1; pcl = eq; end // R8
            if (op == 4'hD) begin ird = 1; pcl = gt; end
            if (op == 4'hE) begin ird = 1; pcl = ng; end
            if (op == 4'h8) begin pcd = 1; acl = 1; end
            if (op == 4'h9) si = 1;                      // R9
            if (op == 4'hA) begin sdr = 1; acl = 1; end
            if (op == 4'hF) begin if (f[0]) sd = 1; else si = 1; end
            if (op == 4'hB) begin ior = 1; acl = 1; end  // R10
            if (op == 4'hC) begin acd = 1; ios = 1; end
        end
        if (p == 4) begin
            if (op == 4'h1) begin mrd = 1; mdl = 1; end
            if (op == 4'h2) begin acd = 1; mwr = 1; end
            if (op == 4'h9) begin acd = 1; sl = 1; end
            if (op == 4'hA) sd = 1;
        end
        if (p == 5 && op == 4'h1) begin mdd = 1; acl = 1; end
        return {pcd, pci, pcl, mar, mrd, mwr, mdl, mdd, irl, ird, acl, acd, bl, als, ald,
                si, sd, sl, sdr, ios, ior};
    endfunction

    function automatic string op_tag(int p, logic [3:0] op);
        if (p < 3) return "R3";
        case (op)
            4'h0, 4'h1, 4'h2, 4'h5, 4'h8: return "R5";
            4'h3:                   return "R6";
            4'h4, 4'h6:             return "R7";
            4'h7, 4'hD, 4'hE:       return "R8";
            4'h9, 4'hA, 4'hF:       return "R9";
            default:                return "R10";
        endcase
    endfunction

    initial begin
        #(20.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pc_exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", {26'd0, phase_o}, 32'h1, "phase under reset");
        check("R2", {24'd0, pc_o}, 32'h0, "pc under reset");
        rst = 1'b0;
        pc_exp = 8'h00;
        for (int op = 0; op < 16; op++) begin
            for (int fl = 0; fl < 8; fl++) begin
                logic [7:0] f, tgt;
                logic       taken;
                f   = 8'(op * 37 + fl * 11 + 3);
                tgt = 8'(op * 16 + fl * 5 + 9);
                eq_i = fl[0]; gt_i = fl[1]; neg_i = fl[2];
                taken = (op == 4 || op == 6) || (op == 7 && fl[0]) ||
                        (op == 13 && fl[1]) || (op == 14 && fl[2]);
                for (int p = 0; p < 6; p++) begin
                    bus_i = (p == 2) ? {4'(op), f} : (p == 3) ? {4'h0, tgt} : 12'h000;
                    #1;
                    if (p == 0)
                        check(taken ? "R7" : "R3", {24'd0, pc_o}, {24'd0, pc_exp}, "pc at T0");
                    check("R1", {26'd0, phase_o}, 32'h1 << p, "phase");
                    check(op_tag(p, 4'(op)), {11'd0, got_vec()},
                          {11'd0, exp_vec(p, 4'(op), f, eq_i, gt_i, neg_i)}, "strobes");
                    check("R11", $countones({pc_drive_o, mdr_drive_o, ir_drive_o, acc_drive_o,
                          alu_drive_o, stk_drive_o, io_recv_o}) > 1, 0, "bus sources");
                    if (p == 3) begin
                        check("R3", {24'd0, pc_o}, {24'd0, pc_exp + 8'd1}, "pc after fetch");
                        check("R4", {20'd0, opcode_o, operand_o}, {20'd0, 4'(op), f}, "latched word");
                        check("R4", {26'd0, micro_o}, {26'd0, f[5:0]}, "micro field");
                    end
                    if (p == 5)
                        check("R4", {20'd0, opcode_o, operand_o}, {20'd0, 4'(op), f}, "held word");
                    @(negedge clk);
                end
                pc_exp = taken ? tgt : pc_exp + 8'd1;
            end
        end
        // reset in the middle of an instruction
        #1;
        check("R7", {24'd0, pc_o}, {24'd0, pc_exp}, "pc before reset test");
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R2", {26'd0, phase_o}, 32'h1, "phase after mid reset");
        check("R2", {24'd0, pc_o}, 32'h0, "pc after mid reset");
        check("R3", {11'd0, got_vec()}, {11'd0, exp_vec(0, 4'h0, 8'h0, 0, 0, 0)}, "T0 after reset");
        @(negedge clk);
        #1;
        check("R1", {26'd0, phase_o}, 32'h2, "phase T1 after reset");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule